// File: doc/BRIEF.md
# Error Status and First-Error Logging Registers

This block keeps the error-reporting registers of one function of a serial-link endpoint. The link and transaction layers signal each detected error with a one-cycle pulse on a dedicated bit of one of two 32-bit event buses. One bus carries uncorrectable errors and the other carries correctable errors. Each pulse sets a sticky status bit. Per-bit mask and severity registers then decide whether the event produces a correctable, non-fatal or fatal message request toward the host.

When the first unmasked uncorrectable error arrives, the block freezes a four-DWORD copy of the offending packet header. It also records the bit position of that error. Both stay frozen until software clears the status bit the pointer names. Software reaches every register through a simple DWORD port, addressed by a byte offset measured from the start of the register structure. Read data is registered.

Top module: `err_report_regs`

## Requirements
- R1: A pulse on an implemented bit of `unc_err_i` or `cor_err_i` sets the matching bit of the uncorrectable status register (+04h) or the correctable status register (+10h). The bit is visible from the next cycle. It is set whether or not the bit is masked. The implemented uncorrectable bits are 4, 5 and 12 to 21. The implemented correctable bits are 0, 6, 7, 8, 12 and 13. Unimplemented bits always read 0.
- R2: A status bit stays set until software writes 1 to that bit position at its status offset. Writing 0 leaves the bit alone. If an error pulse and a clearing write hit the same bit in the same cycle, the bit stays set.
- R3: The uncorrectable mask (+08h), uncorrectable severity (+0Ch) and correctable mask (+14h) are read/write on implemented bits only. Both masks reset to 0. Severity resets to 0x0006_2030, which marks bits 4, 5, 13, 17 and 18 as fatal.
- R4: An unmasked uncorrectable error raises `msg_fatal_o` for exactly one cycle when its severity bit is 1. It raises `msg_nonfatal_o` for exactly one cycle when its severity bit is 0. The pulse appears in the cycle after the error pulse.
- R5: An unmasked correctable error raises `msg_cor_o` for one cycle, in the cycle after the error pulse. A mask bit of 1 suppresses the message for that error.
- R6: Offset +00h reads {next offset[31:20], version[19:16], identifier[15:0]} from parameters. With the default parameters it reads 0x0002_0001.
- R7: The first unmasked uncorrectable error copies `err_hdr_i` into the header log at +1Ch..+28h. Log DWORD k at +1Ch+4k holds `err_hdr_i[32k+31:32k]`. The same error stores its bit position in control bits [4:0] (+18h).
- R8: The log and pointer stay frozen while the status bit named by the pointer remains set. Clearing any other status bit does not re-arm them. Once software clears that bit, the next unmasked uncorrectable error captures again. Masked uncorrectable errors never capture.
- R9: When several unmasked uncorrectable errors arrive in the same cycle, the pointer takes the lowest-numbered bit.
- R10: Control bits 5 and 7 are read-only capability flags taken from parameters. Bits 6 and 8 are writable enables, reset to 0, that drive `ecrc_gen_en_o` and `ecrc_chk_en_o`. An enable can only be set when its capability flag is 1.
- R11: `reg_rdata_o` carries the addressed register in the cycle after `reg_rd_i`. Unmapped offsets read 0. Writes to read-only registers or fields have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| unc_err_i | input | 32 | Uncorrectable error event pulses, one per bit |
| cor_err_i | input | 32 | Correctable error event pulses, one per bit |
| err_hdr_i | input | 128 | Header of the packet tied to the current uncorrectable event |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_ofs_i | input | 8 | Byte offset from the structure start (DWORD aligned) |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| msg_cor_o | output | 1 | Correctable message request pulse |
| msg_nonfatal_o | output | 1 | Non-fatal message request pulse |
| msg_fatal_o | output | 1 | Fatal message request pulse |
| ecrc_gen_en_o | output | 1 | End-to-end CRC generation enable |
| ecrc_chk_en_o | output | 1 | End-to-end CRC check enable |

## Verification
The bench builds the block with its default parameters. These give an 8-bit offset, four header DWORDs, the standard implemented-bit sets and severity reset value, and both CRC capability flags set to 1. Because both flags are set, the writable enable bits and the two enable outputs can be exercised. The default masks also let the bench observe the unimplemented bits reading 0 after an all-ones write.

With these values the bench can reach a freeze held across an unrelated clear, a re-arm followed by a simultaneous two-bit capture, and a masked event after re-arm. It also reaches severity overrides in both directions and a pulse colliding with a clearing write.

// File: rtl/errrep_pkg.sv
package errrep_pkg;
  localparam int REG_W = 32;
  localparam int PTR_W = 5;

  // DWORD indices of the register structure
  localparam int IDX_HDR  = 0;
  localparam int IDX_UST  = 1;
  localparam int IDX_UMSK = 2;
  localparam int IDX_USEV = 3;
  localparam int IDX_CST  = 4;
  localparam int IDX_CMSK = 5;
  localparam int IDX_CTL  = 6;
  localparam int IDX_LOG0 = 7;

  // control register field positions
  localparam int CTL_GEN_CAP = 5;
  localparam int CTL_GEN_EN  = 6;
  localparam int CTL_CHK_CAP = 7;
  localparam int CTL_CHK_EN  = 8;

  localparam logic [REG_W-1:0] UNC_IMPL_DEF = 32'h003F_F030;
  localparam logic [REG_W-1:0] COR_IMPL_DEF = 32'h0000_31C1;
  localparam logic [REG_W-1:0] UNC_SEV_DEF  = 32'h0006_2030;

  function automatic logic [PTR_W-1:0] lowest_set(input logic [REG_W-1:0] v);
    lowest_set = '0;
    for (int i = REG_W - 1; i >= 0; i--) begin
      if (v[i]) lowest_set = PTR_W'(i);
    end
  endfunction
endpackage

// File: rtl/errrep_status_bank.sv
// Sticky event-set, write-one-to-clear status register.
module errrep_status_bank #(
  parameter int          W    = 32,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] clr_data_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] cleared_o
);
  logic [W-1:0] stat_q;
  logic [W-1:0] set_v;
  logic [W-1:0] clr_v;

  assign set_v     = evt_i & IMPL;
  assign clr_v     = clr_we_i ? (clr_data_i & IMPL) : '0;
  // a bit that is really dropped this cycle (set wins over clear)
  assign cleared_o = stat_q & clr_v & ~set_v;

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= (stat_q & ~clr_v) | set_v;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/errrep_cfg_reg.sv
// Plain read/write configuration register limited to implemented bits.
module errrep_cfg_reg #(
  parameter int           W       = 32,
  parameter logic [W-1:0] IMPL    = '1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst)       q_o <= RST_VAL & IMPL;
    else if (we_i) q_o <= wdata_i & IMPL;
  end
endmodule

// File: rtl/errrep_first_log.sv
// First-error pointer and header capture, re-armed by clearing the named status bit.
module errrep_first_log
  import errrep_pkg::*;
#(
  parameter int HDR_DW = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [REG_W-1:0]        cand_i,
  input  logic [REG_W-1:0]        cleared_i,
  input  logic [HDR_DW*REG_W-1:0] hdr_i,
  output logic [PTR_W-1:0]        ptr_o,
  output logic [HDR_DW*REG_W-1:0] log_o,
  output logic                    valid_o,
  output logic                    rearm_o
);
  logic [HDR_DW-1:0][REG_W-1:0] log_q;
  logic [PTR_W-1:0]             ptr_q;
  logic                         valid_q;
  logic                         armed;
  logic                         capture;

  assign rearm_o = valid_q & cleared_i[ptr_q];
  assign armed   = ~valid_q | rearm_o;
  assign capture = armed & (|cand_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      ptr_q   <= '0;
      log_q   <= '0;
    end else if (capture) begin
      valid_q <= 1'b1;
      ptr_q   <= lowest_set(cand_i);
      log_q   <= hdr_i;
    end else if (rearm_o) begin
      valid_q <= 1'b0;
    end
  end

  assign ptr_o   = ptr_q;
  assign log_o   = log_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/errrep_msg_gen.sv
// Registered one-cycle message requests per error class.
module errrep_msg_gen
  import errrep_pkg::*;
#(
  parameter logic [REG_W-1:0] UNC_IMPL = UNC_IMPL_DEF,
  parameter logic [REG_W-1:0] COR_IMPL = COR_IMPL_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] unc_evt_i,
  input  logic [REG_W-1:0] unc_mask_i,
  input  logic [REG_W-1:0] unc_sev_i,
  input  logic [REG_W-1:0] cor_evt_i,
  input  logic [REG_W-1:0] cor_mask_i,
  output logic             msg_cor_o,
  output logic             msg_nonfatal_o,
  output logic             msg_fatal_o
);
  logic [REG_W-1:0] unc_live;
  logic [REG_W-1:0] cor_live;

  assign unc_live = unc_evt_i & UNC_IMPL & ~unc_mask_i;
  assign cor_live = cor_evt_i & COR_IMPL & ~cor_mask_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_cor_o      <= 1'b0;
      msg_nonfatal_o <= 1'b0;
      msg_fatal_o    <= 1'b0;
    end else begin
      msg_cor_o      <= |cor_live;
      msg_nonfatal_o <= |(unc_live & ~unc_sev_i);
      msg_fatal_o    <= |(unc_live & unc_sev_i);
    end
  end
endmodule

// File: rtl/err_report_regs.sv
module err_report_regs
  import errrep_pkg::*;
#(
  parameter int               OFS_W        = 8,
  parameter int               HDR_DW       = 4,
  parameter logic [REG_W-1:0] UNC_IMPL     = UNC_IMPL_DEF,
  parameter logic [REG_W-1:0] COR_IMPL     = COR_IMPL_DEF,
  parameter logic [REG_W-1:0] UNC_SEV_RST  = UNC_SEV_DEF,
  parameter logic [15:0]      CAP_ID       = 16'h0001,
  parameter logic [3:0]       CAP_VER      = 4'h2,
  parameter logic [11:0]      NEXT_OFS     = 12'h000,
  parameter bit               ECRC_GEN_CAP = 1'b1,
  parameter bit               ECRC_CHK_CAP = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [REG_W-1:0]        unc_err_i,
  input  logic [REG_W-1:0]        cor_err_i,
  input  logic [HDR_DW*REG_W-1:0] err_hdr_i,
  input  logic                    reg_wr_i,
  input  logic                    reg_rd_i,
  input  logic [OFS_W-1:0]        reg_ofs_i,
  input  logic [REG_W-1:0]        reg_wdata_i,
  output logic [REG_W-1:0]        reg_rdata_o,
  output logic                    msg_cor_o,
  output logic                    msg_nonfatal_o,
  output logic                    msg_fatal_o,
  output logic                    ecrc_gen_en_o,
  output logic                    ecrc_chk_en_o
);
  localparam int IDX_W = OFS_W - 2;

  logic [IDX_W-1:0]        widx;
  logic                    unused_lsb;
  logic [REG_W-1:0]        unc_stat, unc_cleared, unc_mask, unc_sev;
  logic [REG_W-1:0]        cor_stat, cor_cleared_unused, cor_mask;
  logic [PTR_W-1:0]        fep;
  logic [HDR_DW*REG_W-1:0] hdr_log;
  logic                    log_valid;
  logic                    rearm;
  logic                    gen_en_q, chk_en_q;
  logic [REG_W-1:0]        ctl_word;
  logic [REG_W-1:0]        rd_mux;

  assign widx       = reg_ofs_i[OFS_W-1:2];
  assign unused_lsb = ^reg_ofs_i[1:0];

  function automatic logic wr_at(input int idx);
    return reg_wr_i && (widx == IDX_W'(idx));
  endfunction

  errrep_status_bank #(.W(REG_W), .IMPL(UNC_IMPL)) u_unc_stat (
    .clk(clk), .rst(rst), .evt_i(unc_err_i),
    .clr_we_i(wr_at(IDX_UST)), .clr_data_i(reg_wdata_i),
    .stat_o(unc_stat), .cleared_o(unc_cleared)
  );

  errrep_status_bank #(.W(REG_W), .IMPL(COR_IMPL)) u_cor_stat (
    .clk(clk), .rst(rst), .evt_i(cor_err_i),
    .clr_we_i(wr_at(IDX_CST)), .clr_data_i(reg_wdata_i),
    .stat_o(cor_stat), .cleared_o(cor_cleared_unused)
  );

  errrep_cfg_reg #(.W(REG_W), .IMPL(UNC_IMPL), .RST_VAL('0)) u_unc_mask (
    .clk(clk), .rst(rst), .we_i(wr_at(IDX_UMSK)), .wdata_i(reg_wdata_i), .q_o(unc_mask)
  );

  errrep_cfg_reg #(.W(REG_W), .IMPL(UNC_IMPL), .RST_VAL(UNC_SEV_RST)) u_unc_sev (
    .clk(clk), .rst(rst), .we_i(wr_at(IDX_USEV)), .wdata_i(reg_wdata_i), .q_o(unc_sev)
  );

  errrep_cfg_reg #(.W(REG_W), .IMPL(COR_IMPL), .RST_VAL('0)) u_cor_mask (
    .clk(clk), .rst(rst), .we_i(wr_at(IDX_CMSK)), .wdata_i(reg_wdata_i), .q_o(cor_mask)
  );

  errrep_first_log #(.HDR_DW(HDR_DW)) u_first (
    .clk(clk), .rst(rst),
    .cand_i(unc_err_i & UNC_IMPL & ~unc_mask),
    .cleared_i(unc_cleared), .hdr_i(err_hdr_i),
    .ptr_o(fep), .log_o(hdr_log), .valid_o(log_valid), .rearm_o(rearm)
  );

  errrep_msg_gen #(.UNC_IMPL(UNC_IMPL), .COR_IMPL(COR_IMPL)) u_msg (
    .clk(clk), .rst(rst),
    .unc_evt_i(unc_err_i), .unc_mask_i(unc_mask), .unc_sev_i(unc_sev),
    .cor_evt_i(cor_err_i), .cor_mask_i(cor_mask),
    .msg_cor_o(msg_cor_o), .msg_nonfatal_o(msg_nonfatal_o), .msg_fatal_o(msg_fatal_o)
  );

  // CRC enables: writable only where the capability is present
  always_ff @(posedge clk) begin
    if (rst) begin
      gen_en_q <= 1'b0;
      chk_en_q <= 1'b0;
    end else if (wr_at(IDX_CTL)) begin
      gen_en_q <= ECRC_GEN_CAP & reg_wdata_i[CTL_GEN_EN];
      chk_en_q <= ECRC_CHK_CAP & reg_wdata_i[CTL_CHK_EN];
    end
  end

  assign ecrc_gen_en_o = gen_en_q;
  assign ecrc_chk_en_o = chk_en_q;

  always_comb begin
    ctl_word              = '0;
    ctl_word[PTR_W-1:0]   = fep;
    ctl_word[CTL_GEN_CAP] = ECRC_GEN_CAP;
    ctl_word[CTL_GEN_EN]  = gen_en_q;
    ctl_word[CTL_CHK_CAP] = ECRC_CHK_CAP;
    ctl_word[CTL_CHK_EN]  = chk_en_q;
  end

  always_comb begin
    rd_mux = '0;
    case (widx)
      IDX_W'(IDX_HDR):  rd_mux = {NEXT_OFS, CAP_VER, CAP_ID};
      IDX_W'(IDX_UST):  rd_mux = unc_stat;
      IDX_W'(IDX_UMSK): rd_mux = unc_mask;
      IDX_W'(IDX_USEV): rd_mux = unc_sev;
      IDX_W'(IDX_CST):  rd_mux = cor_stat;
      IDX_W'(IDX_CMSK): rd_mux = cor_mask;
      IDX_W'(IDX_CTL):  rd_mux = ctl_word;
      default:          rd_mux = '0;
    endcase
    for (int k = 0; k < HDR_DW; k++) begin
      if (widx == IDX_W'(IDX_LOG0 + k)) rd_mux = hdr_log[k*REG_W +: REG_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           reg_rdata_o <= '0;
    else if (reg_rd_i) reg_rdata_o <= rd_mux;
  end
endmodule

// File: rtl/err_report_regs_chk.sv
module err_report_regs_chk
  import errrep_pkg::*;
#(
  parameter int               OFS_W    = 8,
  parameter int               HDR_DW   = 4,
  parameter logic [REG_W-1:0] COR_IMPL = COR_IMPL_DEF
) (
  input logic                    clk,
  input logic                    rst,
  input logic [REG_W-1:0]        unc_err_i,
  input logic [REG_W-1:0]        cor_err_i,
  input logic                    reg_wr_i,
  input logic [OFS_W-1:0]        reg_ofs_i,
  input logic [REG_W-1:0]        reg_wdata_i,
  input logic [REG_W-1:0]        unc_stat,
  input logic [REG_W-1:0]        unc_mask,
  input logic [REG_W-1:0]        unc_sev,
  input logic [REG_W-1:0]        cor_mask,
  input logic                    msg_cor_o,
  input logic                    msg_fatal_o,
  input logic                    log_valid,
  input logic                    rearm,
  input logic [HDR_DW*REG_W-1:0] hdr_log
);
  logic             ust_wr;
  logic [REG_W-1:0] ust_clr_req;

  assign ust_wr      = reg_wr_i && (reg_ofs_i[OFS_W-1:2] == (OFS_W-2)'(IDX_UST));
  assign ust_clr_req = ust_wr ? reg_wdata_i : '0;

  // R1: a status bit only rises after an event pulse on that bit
  p_set_only_by_event_r1: assert property (@(posedge clk) disable iff (rst)
    ((unc_stat & ~$past(unc_stat)) & ~$past(unc_err_i)) == '0);

  // R2: a status bit only falls after a write of 1 to it
  p_clear_only_by_w1c_r2: assert property (@(posedge clk) disable iff (rst)
    (($past(unc_stat) & ~unc_stat) & ~$past(ust_clr_req)) == '0);

  // R4: a fatal request needs an unmasked fatal-severity event one cycle earlier
  p_fatal_cause_r4: assert property (@(posedge clk) disable iff (rst)
    msg_fatal_o |-> $past(|(unc_err_i & ~unc_mask & unc_sev)));

  // R5: a correctable request needs an unmasked correctable event one cycle earlier
  p_cor_cause_r5: assert property (@(posedge clk) disable iff (rst)
    msg_cor_o |-> $past(|(cor_err_i & ~cor_mask & COR_IMPL)));

  // R8: the header log holds while the capture is frozen
  p_log_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(log_valid) && !$past(rearm)) |-> $stable(hdr_log));
endmodule

bind err_report_regs err_report_regs_chk #(
  .OFS_W(OFS_W), .HDR_DW(HDR_DW), .COR_IMPL(COR_IMPL)
) u_err_report_regs_chk (
  .clk(clk), .rst(rst), .unc_err_i(unc_err_i), .cor_err_i(cor_err_i),
  .reg_wr_i(reg_wr_i), .reg_ofs_i(reg_ofs_i), .reg_wdata_i(reg_wdata_i),
  .unc_stat(unc_stat), .unc_mask(unc_mask), .unc_sev(unc_sev), .cor_mask(cor_mask),
  .msg_cor_o(msg_cor_o), .msg_fatal_o(msg_fatal_o),
  .log_valid(log_valid), .rearm(rearm), .hdr_log(hdr_log)
);

// File: tb/err_report_regs_bench.sv
`timescale 1ns/1ps
module err_report_regs_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [31:0]  unc_err_i = '0;
  logic [31:0]  cor_err_i = '0;
  logic [127:0] err_hdr_i = '0;
  logic         reg_wr_i = 1'b0;
  logic         reg_rd_i = 1'b0;
  logic [7:0]   reg_ofs_i = '0;
  logic [31:0]  reg_wdata_i = '0;
  logic [31:0]  reg_rdata_o;
  logic         msg_cor_o, msg_nonfatal_o, msg_fatal_o;
  logic         ecrc_gen_en_o, ecrc_chk_en_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  localparam logic [127:0] H1 = 128'h0A0B0C0D_11121314_21222324_31323334;
  localparam logic [127:0] H2 = 128'hDEADBEEF_CAFEF00D_01020304_55667788;
  localparam logic [127:0] H3 = 128'h99AA_BBCC_4444_3333_2222_1111_7777_8888;
  localparam logic [127:0] H4 = 128'hFFFF0000_EEEE1111_DDDD2222_CCCC3333;

  always #2 clk = ~clk;

  err_report_regs u_err_report_regs (
    .clk(clk), .rst(rst), .unc_err_i(unc_err_i), .cor_err_i(cor_err_i),
    .err_hdr_i(err_hdr_i), .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i),
    .reg_ofs_i(reg_ofs_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .msg_cor_o(msg_cor_o), .msg_nonfatal_o(msg_nonfatal_o), .msg_fatal_o(msg_fatal_o),
    .ecrc_gen_en_o(ecrc_gen_en_o), .ecrc_chk_en_o(ecrc_chk_en_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] ofs, input logic [31:0] d);
    @(negedge clk);
    reg_wr_i = 1'b1; reg_ofs_i = ofs; reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] ofs, output logic [31:0] d);
    @(negedge clk);
    reg_rd_i = 1'b1; reg_ofs_i = ofs;
    @(negedge clk);
    reg_rd_i = 1'b0;
    d = reg_rdata_o;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] ofs, input logic [31:0] exp);
    logic [31:0] d;
    rd(ofs, d);
    chk(tag, d, exp);
  endtask

  // drive one pulse, check the message triple the next cycle, then idle
  task automatic pulse(input string tag, input logic [31:0] u, input logic [31:0] c,
                       input logic [2:0] exp_cnf);
    @(negedge clk);
    unc_err_i = u; cor_err_i = c;
    @(negedge clk);
    unc_err_i = '0; cor_err_i = '0;
    chk(tag, {29'd0, msg_cor_o, msg_nonfatal_o, msg_fatal_o}, {29'd0, exp_cnf});
    @(negedge clk);
    chk({tag, " one-cycle"}, {29'd0, msg_cor_o, msg_nonfatal_o, msg_fatal_o}, 32'd0);
  endtask

  task automatic t_reset;
    chk("R4 R5 msgs idle after reset", {29'd0, msg_cor_o, msg_nonfatal_o, msg_fatal_o}, 0);
    chk("R10 enables reset", {30'd0, ecrc_gen_en_o, ecrc_chk_en_o}, 0);
    rd_chk("R6 header word", 8'h00, 32'h0002_0001);
    rd_chk("R1 unc status reset", 8'h04, 0);
    rd_chk("R3 unc mask reset", 8'h08, 0);
    rd_chk("R3 severity reset", 8'h0C, 32'h0006_2030);
    rd_chk("R1 cor status reset", 8'h10, 0);
    rd_chk("R3 cor mask reset", 8'h14, 0);
    rd_chk("R10 control reset", 8'h18, 32'h0000_00A0);
    rd_chk("R7 log reset", 8'h1C, 0);
    rd_chk("R11 unmapped read", 8'h2C, 0);
  endtask

  task automatic t_first_capture;
    err_hdr_i = H1;
    pulse("R4 nonfatal bit14", 32'h1 << 14, 0, 3'b010);
    rd_chk("R1 unc status bit14", 8'h04, 32'h1 << 14);
    rd_chk("R7 pointer 14", 8'h18, 32'hA0 | 32'd14);
    for (int k = 0; k < 4; k++) rd_chk("R7 log dword", 8'h1C + 8'(4*k), H1[32*k +: 32]);
  endtask

  task automatic t_freeze;
    err_hdr_i = H2;
    pulse("R4 fatal bit5", 32'h1 << 5, 0, 3'b001);
    rd_chk("R1 both unc bits", 8'h04, (32'h1 << 14) | (32'h1 << 5));
    rd_chk("R8 pointer frozen", 8'h18, 32'hA0 | 32'd14);
    rd_chk("R8 log frozen", 8'h1C, H1[31:0]);
  endtask

  task automatic t_w1c_rearm;
    wr(8'h04, 32'h0);
    rd_chk("R2 write 0 no effect", 8'h04, (32'h1 << 14) | (32'h1 << 5));
    wr(8'h04, 32'h1 << 5);
    rd_chk("R2 clear bit5", 8'h04, 32'h1 << 14);
    err_hdr_i = H3;
    pulse("R8 other-bit clear keeps freeze, fatal 18", 32'h1 << 18, 0, 3'b001);
    rd_chk("R8 pointer still 14", 8'h18, 32'hA0 | 32'd14);
    wr(8'h04, 32'hFFFF_FFFF);
    rd_chk("R2 clear all", 8'h04, 0);
    pulse("R9 simultaneous 20 and 17", (32'h1 << 20) | (32'h1 << 17), 0, 3'b011);
    rd_chk("R9 lowest bit wins", 8'h18, 32'hA0 | 32'd17);
    rd_chk("R7 recapture log", 8'h28, H3[127:96]);
  endtask

  task automatic t_mask;
    wr(8'h08, 32'h1 << 12);
    rd_chk("R3 unc mask rw", 8'h08, 32'h1 << 12);
    wr(8'h04, 32'hFFFF_FFFF);
    err_hdr_i = H4;
    pulse("R5 masked unc no msg", 32'h1 << 12, 0, 3'b000);
    rd_chk("R1 masked still sets status", 8'h04, 32'h1 << 12);
    rd_chk("R8 masked no capture", 8'h1C, H3[31:0]);
    wr(8'h08, 32'hFFFF_FFFF);
    rd_chk("R3 unimplemented mask bits 0", 8'h08, 32'h003F_F030);
    wr(8'h08, 32'h0);
  endtask

  task automatic t_severity;
    wr(8'h0C, 32'h0);
    rd_chk("R3 severity cleared", 8'h0C, 0);
    pulse("R4 bit4 downgraded", 32'h1 << 4, 0, 3'b010);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd_chk("R3 severity implemented bits", 8'h0C, 32'h003F_F030);
    pulse("R4 bit14 upgraded", 32'h1 << 14, 0, 3'b001);
    rd_chk("R7 pointer after rearm is 4", 8'h18, 32'hA0 | 32'd4);
    wr(8'h0C, 32'h0006_2030);
  endtask

  task automatic t_cor;
    pulse("R5 cor message", 0, 32'hFFFF_FFFF, 3'b100);
    rd_chk("R1 cor implemented bits", 8'h10, 32'h0000_31C1);
    wr(8'h14, 32'hFFFF_FFFF);
    rd_chk("R3 cor mask rw", 8'h14, 32'h0000_31C1);
    wr(8'h10, 32'hFFFF_FFFF);
    pulse("R5 cor masked", 0, 32'h1 << 6, 3'b000);
    rd_chk("R1 masked cor sets status", 8'h10, 32'h40);
  endtask

  task automatic t_collide;
    @(negedge clk);
    reg_wr_i = 1'b1; reg_ofs_i = 8'h10; reg_wdata_i = 32'h0000_00C0;
    cor_err_i = 32'h1 << 7;
    @(negedge clk);
    reg_wr_i = 1'b0; cor_err_i = '0;
    rd_chk("R2 set wins over clear", 8'h10, 32'h80);
  endtask

  task automatic t_control;
    wr(8'h18, 32'hFFFF_FFFF);
    chk("R10 enable outputs", {30'd0, ecrc_gen_en_o, ecrc_chk_en_o}, 32'd3);
    rd_chk("R10 control rw, pointer RO", 8'h18, 32'h1E0 | 32'd4);
    wr(8'h18, 32'h0);
    chk("R10 enables off", {30'd0, ecrc_gen_en_o, ecrc_chk_en_o}, 32'd0);
    wr(8'h00, 32'hFFFF_FFFF);
    rd_chk("R11 RO header write ignored", 8'h00, 32'h0002_0001);
    rd_chk("R11 unmapped high", 8'h3C, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_first_capture();
    t_freeze();
    t_w1c_rearm();
    t_mask();
    t_severity();
    t_cor();
    t_collide();
    t_control();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule